// File: doc/BRIEF.md
# CAN Node Fault Confinement Controller

This block tracks how trustworthy a CAN node currently is on the bus. It holds the transmit error count and the receive error count, applies the increment and decrement requests that the protocol engine raises, and derives the node's bus state from the two counts. It also decides whether the node may transmit. The protocol engine decides how large each adjustment is. Error-flag signalling is outside this block.

Each time the module is enabled it starts in a sync state. It stays there until it sees a run of eleven recessive bits on the bus. From then on the state follows the counters: error active, error warning, error passive, and bus off. Bus off is entered when the transmit count passes 255. The node leaves bus off only after it has counted 128 separate runs of eleven recessive bits. On leaving, both counts are cleared and the node returns to error active. Bus bits count only on cycles where the bit strobe is high.

Top module: `can_fault_conf`

## Requirements
- R1: After a synchronous reset the state code is 0 (sync), both counts read 0, and `tx_allowed` is low.
- R2: In sync, the state changes to error active (code 1) once 11 consecutive strobed bits have been recessive (`bus_rx`=1). Any strobed dominant bit (`bus_rx`=0) restarts that run from zero.
- R3: Outside sync and bus off, a count increment request adds its amount. The transmit count (9 bits) saturates at 511 and the receive count (8 bits) saturates at 255. A decrement request subtracts 1 and stops at 0. When both requests arrive in the same cycle, the increment wins. Each change shows in the cycle after the request.
- R4: The state becomes error warning (code 2) when either count exceeds 95 and neither exceeds 127.
- R5: The state becomes error passive (code 3) when either count exceeds 127 and the transmit count is at most 255.
- R6: Error passive falls back to warning only once both counts are below 128. Warning falls back to active only once both counts are below 96.
- R7: The state becomes bus off (code 4) in the same cycle that the transmit count first exceeds 255.
- R8: In bus off, counter requests are ignored. After the 128th completed run of 11 recessive strobed bits, the state becomes error active and both counts read 0.
- R9: `tx_allowed` is high in error active, warning and passive, and low in sync and bus off.
- R10: While `enable` is low, the next cycle shows sync with both counts 0 and the recessive run counter cleared.
- R11: In sync, counter requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Module enable; low holds the block in sync with cleared counts |
| bit_tick | input | 1 | Bit strobe; `bus_rx` counts only when this is high |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| tec_inc | input | 1 | Transmit count increment request |
| tec_amt | input | 4 | Transmit count increment amount |
| tec_dec | input | 1 | Transmit count decrement-by-one request |
| rec_inc | input | 1 | Receive count increment request |
| rec_amt | input | 4 | Receive count increment amount |
| rec_dec | input | 1 | Receive count decrement-by-one request |
| tec_out | output | 9 | Transmit error count |
| rec_out | output | 8 | Receive error count |
| state_code | output | 3 | 0 sync, 1 active, 2 warning, 3 passive, 4 bus off |
| tx_allowed | output | 1 | Node may transmit |

## Verification
Every result is registered once. A counter request, a strobed bus bit, or a change of `enable` presented before a rising edge shows on the counts and the state code after that edge. The state uses the updated counts, so a crossing of a threshold and the new state appear together. The bench drives inputs on the falling edge and steps a behavioural model on the rising edge. It compares all four outputs on the next falling edge, so every comparison falls in the cycle where the result is due. Directed checks at the threshold crossings, at saturation and at the 127th and 128th recovery runs use the same one-cycle timing.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    localparam int ADJ_W = 4;

    typedef enum logic [2:0] {
        FC_SYNC    = 3'd0,
        FC_ACTIVE  = 3'd1,
        FC_WARN    = 3'd2,
        FC_PASSIVE = 3'd3,
        FC_BUSOFF  = 3'd4
    } fc_state_e;

    typedef struct packed {
        logic             inc;
        logic [ADJ_W-1:0] amt;
        logic             dec;
    } adj_req_t;

    // Bus-usable states allow transmission.
    function automatic logic may_send(input fc_state_e s);
        return (s == FC_ACTIVE) || (s == FC_WARN) || (s == FC_PASSIVE);
    endfunction

endpackage

// File: rtl/can_fc_runcnt.sv
module can_fc_runcnt #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    input  logic rx,
    output logic run_hit
);
    localparam int RUN_W = $clog2(RUN_LEN);

    logic [RUN_W-1:0] run_q;
    logic             at_end;

    assign at_end  = (run_q == RUN_W'(RUN_LEN - 1));
    assign run_hit = tick && rx && at_end;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_q <= '0;
        end else if (tick) begin
            if (!rx || at_end) run_q <= '0;
            else               run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/can_fc_errcnt.sv
module can_fc_errcnt #(
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 hold,
    input  can_fc_pkg::adj_req_t req,
    output logic [CNT_W-1:0]     cnt_q,
    output logic [CNT_W-1:0]     cnt_d
);
    localparam logic [CNT_W:0] MAXV = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0] sum;

    assign sum = {1'b0, cnt_q} + (CNT_W+1)'(req.amt);

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (!hold) begin
            if (req.inc)
                cnt_d = (sum > MAXV) ? MAXV[CNT_W-1:0] : sum[CNT_W-1:0];
            else if (req.dec && cnt_q != '0)
                cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/can_fc_fsm.sv
module can_fc_fsm #(
    parameter int TEC_W         = 9,
    parameter int REC_W         = 8,
    parameter int WARN_LIM      = 96,
    parameter int PASS_LIM      = 128,
    parameter int OFF_LIM       = 256,
    parameter int RECOVERY_RUNS = 128
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic                  run_hit,
    input  logic [TEC_W-1:0]      tec_d,
    input  logic [REC_W-1:0]      rec_d,
    output can_fc_pkg::fc_state_e state_q,
    output logic                  cnt_clear,
    output logic                  cnt_hold
);
    import can_fc_pkg::*;

    localparam int IDLE_W = $clog2(RECOVERY_RUNS);

    fc_state_e         state_d;
    logic [IDLE_W-1:0] idle_q, idle_d;
    logic              recovered;

    assign recovered = (state_q == FC_BUSOFF) && run_hit &&
                       (idle_q == IDLE_W'(RECOVERY_RUNS - 1));
    assign cnt_clear = !enable || recovered;
    assign cnt_hold  = (state_q == FC_SYNC) || (state_q == FC_BUSOFF);

    always_comb begin
        state_d = state_q;
        idle_d  = idle_q;
        if (!enable) begin
            state_d = FC_SYNC;
            idle_d  = '0;
        end else begin
            unique case (state_q)
                FC_SYNC: if (run_hit) state_d = FC_ACTIVE;
                FC_BUSOFF: begin
                    if (recovered) begin
                        state_d = FC_ACTIVE;
                        idle_d  = '0;
                    end else if (run_hit) begin
                        idle_d = idle_q + 1'b1;
                    end
                end
                default: begin
                    if (32'(tec_d) >= 32'(OFF_LIM)) begin
                        state_d = FC_BUSOFF;
                        idle_d  = '0;
                    end else if (32'(tec_d) >= 32'(PASS_LIM) || 32'(rec_d) >= 32'(PASS_LIM))
                        state_d = FC_PASSIVE;
                    else if (32'(tec_d) >= 32'(WARN_LIM) || 32'(rec_d) >= 32'(WARN_LIM))
                        state_d = FC_WARN;
                    else
                        state_d = FC_ACTIVE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FC_SYNC;
            idle_q  <= '0;
        end else begin
            state_q <= state_d;
            idle_q  <= idle_d;
        end
    end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
    parameter int TEC_W         = 9,
    parameter int REC_W         = 8,
    parameter int RUN_LEN       = 11,
    parameter int RECOVERY_RUNS = 128,
    parameter int WARN_LIM      = 96,
    parameter int PASS_LIM      = 128,
    parameter int OFF_LIM       = 256
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         enable,
    input  logic                         bit_tick,
    input  logic                         bus_rx,
    input  logic                         tec_inc,
    input  logic [can_fc_pkg::ADJ_W-1:0] tec_amt,
    input  logic                         tec_dec,
    input  logic                         rec_inc,
    input  logic [can_fc_pkg::ADJ_W-1:0] rec_amt,
    input  logic                         rec_dec,
    output logic [TEC_W-1:0]             tec_out,
    output logic [REC_W-1:0]             rec_out,
    output logic [2:0]                   state_code,
    output logic                         tx_allowed
);
    import can_fc_pkg::*;

    adj_req_t          tec_req, rec_req;
    fc_state_e         state;
    logic              run_hit, cnt_clear, cnt_hold;
    logic [TEC_W-1:0]  tec_d;
    logic [REC_W-1:0]  rec_d;

    assign tec_req = '{inc: tec_inc, amt: tec_amt, dec: tec_dec};
    assign rec_req = '{inc: rec_inc, amt: rec_amt, dec: rec_dec};

    can_fc_runcnt #(.RUN_LEN(RUN_LEN)) u_run (
        .clk(clk), .rst(rst), .clear(!enable),
        .tick(bit_tick), .rx(bus_rx), .run_hit(run_hit)
    );

    can_fc_errcnt #(.CNT_W(TEC_W)) u_tec (
        .clk(clk), .rst(rst), .clear(cnt_clear), .hold(cnt_hold),
        .req(tec_req), .cnt_q(tec_out), .cnt_d(tec_d)
    );

    can_fc_errcnt #(.CNT_W(REC_W)) u_rec (
        .clk(clk), .rst(rst), .clear(cnt_clear), .hold(cnt_hold),
        .req(rec_req), .cnt_q(rec_out), .cnt_d(rec_d)
    );

    can_fc_fsm #(
        .TEC_W(TEC_W), .REC_W(REC_W), .WARN_LIM(WARN_LIM),
        .PASS_LIM(PASS_LIM), .OFF_LIM(OFF_LIM), .RECOVERY_RUNS(RECOVERY_RUNS)
    ) u_fsm (
        .clk(clk), .rst(rst), .enable(enable), .run_hit(run_hit),
        .tec_d(tec_d), .rec_d(rec_d), .state_q(state),
        .cnt_clear(cnt_clear), .cnt_hold(cnt_hold)
    );

    assign state_code = state;
    assign tx_allowed = may_send(state);
endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker #(
    parameter int TEC_W    = 9,
    parameter int REC_W    = 8,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 128,
    parameter int OFF_LIM  = 256
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic [TEC_W-1:0] tec,
    input logic [REC_W-1:0] rec,
    input logic [2:0]       state_code,
    input logic             tx_allowed
);
    logic [31:0] t32, r32;
    assign t32 = 32'(tec);
    assign r32 = 32'(rec);

    assert_active_levels_R4: assert property (@(posedge clk) disable iff (rst)
        state_code == 3'd1 |-> (t32 < 32'(WARN_LIM) && r32 < 32'(WARN_LIM)));

    assert_warn_levels_R6: assert property (@(posedge clk) disable iff (rst)
        state_code == 3'd2 |-> ((t32 >= 32'(WARN_LIM) || r32 >= 32'(WARN_LIM)) &&
                               t32 < 32'(PASS_LIM) && r32 < 32'(PASS_LIM)));

    assert_passive_levels_R5: assert property (@(posedge clk) disable iff (rst)
        state_code == 3'd3 |-> ((t32 >= 32'(PASS_LIM) || r32 >= 32'(PASS_LIM)) &&
                               t32 < 32'(OFF_LIM)));

    assert_busoff_level_R7: assert property (@(posedge clk) disable iff (rst)
        state_code == 3'd4 |-> t32 >= 32'(OFF_LIM));

    assert_tx_blocked_R9: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd0 || state_code == 3'd4) |-> !tx_allowed);

    assert_tx_open_R9: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd1 || state_code == 3'd2 || state_code == 3'd3) |-> tx_allowed);

    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (state_code == 3'd0 && tec == '0 && rec == '0));

    assert_busoff_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd4 && enable) |=>
            (state_code == 3'd4 || (state_code == 3'd1 && tec == '0 && rec == '0)));

    assert_sync_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd0 && enable) |=> (tec == '0 && rec == '0));
endmodule

bind can_fault_conf can_fc_checker #(
    .TEC_W(TEC_W), .REC_W(REC_W), .WARN_LIM(WARN_LIM),
    .PASS_LIM(PASS_LIM), .OFF_LIM(OFF_LIM)
) u_fc_checker (
    .clk(clk), .rst(rst), .enable(enable), .tec(tec_out), .rec(rec_out),
    .state_code(state_code), .tx_allowed(tx_allowed)
);

// File: tb/test_can_fault_conf.sv
module test_can_fault_conf;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       bit_tick = 1'b0, bus_rx = 1'b1;
    logic       tec_inc = 1'b0, tec_dec = 1'b0, rec_inc = 1'b0, rec_dec = 1'b0;
    logic [3:0] tec_amt = '0, rec_amt = '0;
    logic [8:0] tec_out;
    logic [7:0] rec_out;
    logic [2:0] state_code;
    logic       tx_allowed;

    int checks = 0, failures = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_tec = 0, m_rec = 0, m_state = 0, m_run = 0, m_idle = 0;

    always #5 clk = ~clk;

    can_fault_conf i_can_fault_conf (
        .clk(clk), .rst(rst), .enable(enable), .bit_tick(bit_tick), .bus_rx(bus_rx),
        .tec_inc(tec_inc), .tec_amt(tec_amt), .tec_dec(tec_dec),
        .rec_inc(rec_inc), .rec_amt(rec_amt), .rec_dec(rec_dec),
        .tec_out(tec_out), .rec_out(rec_out), .state_code(state_code),
        .tx_allowed(tx_allowed)
    );

    always @(posedge clk) begin
        bit hit;
        if (rst || !enable) begin
            m_tec = 0; m_rec = 0; m_state = 0; m_run = 0; m_idle = 0;
        end else begin
            hit = bit_tick && bus_rx && (m_run == 10);
            if (bit_tick) m_run = (!bus_rx || m_run == 10) ? 0 : m_run + 1;
            if (m_state != 0 && m_state != 4) begin
                if (tec_inc) m_tec = (m_tec + tec_amt > 511) ? 511 : m_tec + tec_amt;
                else if (tec_dec && m_tec > 0) m_tec = m_tec - 1;
                if (rec_inc) m_rec = (m_rec + rec_amt > 255) ? 255 : m_rec + rec_amt;
                else if (rec_dec && m_rec > 0) m_rec = m_rec - 1;
            end
            case (m_state)
                0: if (hit) m_state = 1;
                4: if (hit) begin
                    if (m_idle == 127) begin
                        m_state = 1; m_tec = 0; m_rec = 0; m_idle = 0;
                    end else m_idle = m_idle + 1;
                end
                default: begin
                    if (m_tec > 255) begin m_state = 4; m_idle = 0; end
                    else if (m_tec > 127 || m_rec > 127) m_state = 3;
                    else if (m_tec > 95 || m_rec > 95) m_state = 2;
                    else m_state = 1;
                end
            endcase
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare against the model every cycle
    always @(negedge clk) begin
        if (!rst) begin
            chk(cur_req, "tec", int'(tec_out), m_tec);
            chk(cur_req, "rec", int'(rec_out), m_rec);
            chk(cur_req, "state", int'(state_code), m_state);
            chk("R9", "tx_allowed", int'(tx_allowed),
                (m_state >= 1 && m_state <= 3) ? 1 : 0);
        end
    end

    task automatic bits(input int n, input logic v);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1; bus_rx = v;
            @(negedge clk);
            bit_tick = 1'b0; bus_rx = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic adj(input logic ti, input int ta, input logic td,
                       input logic ri, input int ra, input logic rd);
        tec_inc = ti; tec_amt = 4'(ta); tec_dec = td;
        rec_inc = ri; rec_amt = 4'(ra); rec_dec = rd;
        @(negedge clk);
        tec_inc = 0; tec_dec = 0; rec_inc = 0; rec_dec = 0; tec_amt = 0; rec_amt = 0;
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset state", int'(state_code), 0);
        chk("R1", "reset tec", int'(tec_out), 0);
        chk("R1", "reset tx", int'(tx_allowed), 0);
        enable = 1'b1;
        @(negedge clk);

        cur_req = "R11";
        adj(1, 8, 0, 1, 8, 0);
        chk("R11", "tec in sync", int'(tec_out), 0);
        chk("R11", "rec in sync", int'(rec_out), 0);

        cur_req = "R2";
        bits(6, 1'b1); bits(1, 1'b0); bits(10, 1'b1);
        chk("R2", "still sync after broken run", int'(state_code), 0);
        bits(1, 1'b1);
        chk("R2", "active after 11 recessive", int'(state_code), 1);

        cur_req = "R4";
        for (int i = 0; i < 12; i++) adj(0, 0, 0, 1, 8, 0);
        chk("R4", "rec at 96", int'(rec_out), 96);
        chk("R4", "warning at 96", int'(state_code), 2);
        cur_req = "R5";
        for (int i = 0; i < 4; i++) adj(0, 0, 0, 1, 8, 0);
        chk("R5", "passive at 128", int'(state_code), 3);

        cur_req = "R6";
        adj(0, 0, 0, 0, 0, 1);
        chk("R6", "warning at 127", int'(state_code), 2);
        for (int i = 0; i < 31; i++) adj(0, 0, 0, 0, 0, 1);
        chk("R6", "still warning at 96", int'(state_code), 2);
        adj(0, 0, 0, 0, 0, 1);
        chk("R6", "active at 95", int'(state_code), 1);

        cur_req = "R3";
        for (int i = 0; i < 20; i++) adj(0, 0, 0, 1, 15, 0);
        chk("R3", "rec saturates", int'(rec_out), 255);
        adj(0, 0, 0, 1, 1, 1);
        chk("R3", "inc wins over dec", int'(rec_out), 255);
        for (int i = 0; i < 256; i++) adj(0, 0, 0, 0, 0, 1);
        chk("R3", "rec floor", int'(rec_out), 0);
        adj(1, 3, 1, 0, 0, 0);
        chk("R3", "tec inc wins", int'(tec_out), 3);
        for (int i = 0; i < 5; i++) adj(0, 0, 1, 0, 0, 0);
        chk("R3", "tec floor", int'(tec_out), 0);

        cur_req = "R7";
        for (int i = 0; i < 17; i++) adj(1, 15, 0, 0, 0, 0);
        chk("R7", "tec 255 passive", int'(state_code), 3);
        adj(1, 8, 0, 0, 0, 0);
        chk("R7", "tec 263", int'(tec_out), 263);
        chk("R7", "bus off", int'(state_code), 4);
        chk("R9", "tx blocked in bus off", int'(tx_allowed), 0);

        cur_req = "R8";
        adj(0, 0, 1, 1, 5, 0);
        chk("R8", "tec frozen", int'(tec_out), 263);
        chk("R8", "rec frozen", int'(rec_out), 0);
        bits(5, 1'b1); bits(1, 1'b0);
        for (int i = 0; i < 127; i++) bits(11, 1'b1);
        chk("R8", "bus off after 127 runs", int'(state_code), 4);
        bits(10, 1'b1);
        chk("R8", "bus off one bit short", int'(state_code), 4);
        bits(1, 1'b1);
        chk("R8", "active after 128 runs", int'(state_code), 1);
        chk("R8", "tec cleared", int'(tec_out), 0);

        cur_req = "R10";
        for (int i = 0; i < 8; i++) adj(1, 15, 0, 1, 15, 0);
        enable = 1'b0;
        @(negedge clk);
        chk("R10", "sync on disable", int'(state_code), 0);
        chk("R10", "tec cleared", int'(tec_out), 0);
        enable = 1'b1;
        bits(11, 1'b1);
        chk("R10", "active after resync", int'(state_code), 1);

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule